// File: doc/BRIEF.md
# Execute-in-Place Mode Tracker

This block follows whether the attached serial flash is currently operating in execute-in-place mode, and for every read it tells the read command builder how to form the command. The builder needs three answers: whether the read opcode goes out, whether a mode byte follows the address, and which mode byte to send. Software controls the block through two level inputs. One says that the device is already in execute-in-place mode. The other asks for entry on the next read. When both are low, the block leaves the mode.

Entry and exit through a normal read are deferred. The mode byte that changes the device state only takes effect once that read has run. The tracked state therefore changes on the read-done strobe and not on the request. The immediate path serves devices that wake up already in execute-in-place mode: the first read after it is selected skips the opcode, and the block counts as active from that request onward.

The control inputs are sampled only when a read request is accepted. Changes made while a read is outstanding take effect at the following request. A descriptor is registered on each accepted request and held until the next one.

Top module: `xip_mode_tracker`

## Requirements
- R1: After reset the block is not active (`xip_active_o`=0), and the descriptor reads opcode=1, mode-bits=0, mode value 8'hFF.
- R2: With the block inactive and both control bits low, an accepted read gives opcode=1 and mode-bits=0, and the block stays inactive.
- R3: With the block inactive, `enter_next_i`=1 and `enter_now_i`=0, a read gives opcode=1, mode-bits=1 and value 8'hA0. `xip_active_o` stays 0 while the read is outstanding and reads 1 from the cycle after `rd_done_i`.
- R4: With the block inactive and `enter_now_i`=1, a read gives opcode=0, mode-bits=1 and value 8'hA0, and `xip_active_o` reads 1 from the cycle after the request. `enter_now_i` takes priority over `enter_next_i`.
- R5: With the block active and either control bit high, a read gives opcode=0, mode-bits=1 and value 8'hA0, and the block stays active.
- R6: With the block active and both control bits low, a read gives opcode=0, mode-bits=1 and value 8'hFF. `xip_active_o` stays 1 while that read is outstanding and reads 0 from the cycle after `rd_done_i`.
- R7: Control-bit changes made between an accepted request and its `rd_done_i` leave the current descriptor and state unchanged. They apply at the next request.
- R8: A `rd_req_i` pulse while a read is outstanding is ignored. A `rd_done_i` pulse with no read outstanding is ignored.
- R9: The descriptor is updated one cycle after an accepted request and held until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_now_i | input | 1 | Device already in execute-in-place mode; skip the opcode from the next read |
| enter_next_i | input | 1 | Enter execute-in-place mode through the next read |
| rd_req_i | input | 1 | Single-cycle strobe: a read starts |
| rd_done_i | input | 1 | Single-cycle strobe: the outstanding read has finished |
| send_opcode_o | output | 1 | Current read carries the read opcode |
| send_mode_o | output | 1 | Current read carries a mode byte after the address |
| mode_val_o | output | 8 | Mode byte to send |
| xip_active_o | output | 1 | Device is treated as being in execute-in-place mode |

## Verification
A wrong state shows up at the ports in one of two ways. The state may slip into active or inactive too early or too late, so `xip_active_o` changes a cycle away from the request or the done strobe that should move it. Or the next read's descriptor carries the wrong opcode flag or mode byte, which shows one cycle after that request is accepted. The bench sweeps both starting states against every combination of control bits at request time and every combination during the read, so a wrong transition is seen on the same read or on the read that follows it.

// File: rtl/xip_pkg.sv
package xip_pkg;

    parameter int unsigned XIP_MODE_W = 8;

    typedef enum logic [1:0] {
        XS_NORMAL     = 2'd0,
        XS_ENTER_PEND = 2'd1,
        XS_ACTIVE     = 2'd2,
        XS_EXIT_PEND  = 2'd3
    } xip_state_e;

    typedef struct packed {
        xip_state_e             state;
        logic                   busy;
        logic                   send_op;
        logic                   send_mode;
        logic [XIP_MODE_W-1:0]  mode_val;
    } xip_regs_t;

endpackage

// File: rtl/xip_read_plan.sv
module xip_read_plan
    import xip_pkg::*;
#(
    parameter logic [XIP_MODE_W-1:0] MODE_STAY = 8'hA0,
    parameter logic [XIP_MODE_W-1:0] MODE_EXIT = 8'hFF
) (
    input  xip_state_e              cur_state_i,
    input  logic                    enter_now_i,
    input  logic                    enter_next_i,
    output xip_state_e              req_state_o,
    output logic                    send_op_o,
    output logic                    send_mode_o,
    output logic [XIP_MODE_W-1:0]   mode_val_o
);

    logic dev_in_xip;
    logic want_xip;

    assign dev_in_xip = (cur_state_i == XS_ACTIVE) || (cur_state_i == XS_EXIT_PEND);
    assign want_xip   = enter_now_i || enter_next_i;

    always_comb begin
        req_state_o = cur_state_i;
        send_op_o   = 1'b1;
        send_mode_o = 1'b0;
        mode_val_o  = MODE_EXIT;
        if (dev_in_xip) begin
            send_op_o   = 1'b0;
            send_mode_o = 1'b1;
            if (want_xip) begin
                req_state_o = XS_ACTIVE;
                mode_val_o  = MODE_STAY;
            end else begin
                req_state_o = XS_EXIT_PEND;
                mode_val_o  = MODE_EXIT;
            end
        end else if (enter_now_i) begin
            req_state_o = XS_ACTIVE;
            send_op_o   = 1'b0;
            send_mode_o = 1'b1;
            mode_val_o  = MODE_STAY;
        end else if (enter_next_i) begin
            req_state_o = XS_ENTER_PEND;
            send_mode_o = 1'b1;
            mode_val_o  = MODE_STAY;
        end else begin
            req_state_o = XS_NORMAL;
        end
    end

endmodule

// File: rtl/xip_core.sv
module xip_core
    import xip_pkg::*;
#(
    parameter logic [XIP_MODE_W-1:0] MODE_STAY = 8'hA0,
    parameter logic [XIP_MODE_W-1:0] MODE_EXIT = 8'hFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_req_i,
    input  logic                    rd_done_i,
    input  xip_state_e              plan_state_i,
    input  logic                    plan_op_i,
    input  logic                    plan_mode_i,
    input  logic [XIP_MODE_W-1:0]   plan_val_i,
    output xip_state_e              cur_state_o,
    output logic                    send_opcode_o,
    output logic                    send_mode_o,
    output logic [XIP_MODE_W-1:0]   mode_val_o,
    output logic                    xip_active_o
);

    xip_regs_t r_d, r_q;
    logic      accept;
    logic      finish;

    assign accept = rd_req_i && !r_q.busy;
    assign finish = rd_done_i && r_q.busy;

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.busy      = 1'b1;
            r_d.state     = plan_state_i;
            r_d.send_op   = plan_op_i;
            r_d.send_mode = plan_mode_i;
            r_d.mode_val  = plan_val_i;
        end else if (finish) begin
            r_d.busy = 1'b0;
            case (r_q.state)
                XS_ENTER_PEND: r_d.state = XS_ACTIVE;
                XS_EXIT_PEND:  r_d.state = XS_NORMAL;
                default:       r_d.state = r_q.state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state     <= XS_NORMAL;
            r_q.busy      <= 1'b0;
            r_q.send_op   <= 1'b1;
            r_q.send_mode <= 1'b0;
            r_q.mode_val  <= MODE_EXIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_state_o   = r_q.state;
    assign send_opcode_o = r_q.send_op;
    assign send_mode_o   = r_q.send_mode;
    assign mode_val_o    = r_q.mode_val;
    assign xip_active_o  = (r_q.state == XS_ACTIVE) || (r_q.state == XS_EXIT_PEND);

    AST_FALL_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xip_active_o) |-> $past(rd_done_i)) else $error("active dropped without done"); // R6

    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xip_active_o) |-> ($past(rd_done_i) || !send_opcode_o)) else $error("bad entry"); // R3

    AST_DESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(accept) |-> ($stable(send_opcode_o) && $stable(send_mode_o) && $stable(mode_val_o)))
        else $error("descriptor changed without request"); // R9

    AST_EXIT_NO_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (send_mode_o && mode_val_o == MODE_EXIT) |-> !send_opcode_o) else $error("exit with opcode"); // R6

    AST_ACTIVE_SKIPS_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && xip_active_o) |=> (!send_opcode_o && send_mode_o)) else $error("opcode in xip"); // R5

    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && r_q.busy && !rd_done_i) |=> $stable(xip_active_o)) else $error("busy req acted"); // R8

endmodule

// File: rtl/xip_mode_tracker.sv
module xip_mode_tracker
    import xip_pkg::*;
#(
    parameter logic [XIP_MODE_W-1:0] MODE_STAY = 8'hA0,
    parameter logic [XIP_MODE_W-1:0] MODE_EXIT = 8'hFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enter_now_i,
    input  logic                    enter_next_i,
    input  logic                    rd_req_i,
    input  logic                    rd_done_i,
    output logic                    send_opcode_o,
    output logic                    send_mode_o,
    output logic [XIP_MODE_W-1:0]   mode_val_o,
    output logic                    xip_active_o
);

    xip_state_e              cur_state;
    xip_state_e              plan_state;
    logic                    plan_op;
    logic                    plan_mode;
    logic [XIP_MODE_W-1:0]   plan_val;

    xip_read_plan #(
        .MODE_STAY (MODE_STAY),
        .MODE_EXIT (MODE_EXIT)
    ) i_plan (
        .cur_state_i  (cur_state),
        .enter_now_i  (enter_now_i),
        .enter_next_i (enter_next_i),
        .req_state_o  (plan_state),
        .send_op_o    (plan_op),
        .send_mode_o  (plan_mode),
        .mode_val_o   (plan_val)
    );

    xip_core #(
        .MODE_STAY (MODE_STAY),
        .MODE_EXIT (MODE_EXIT)
    ) i_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_req_i      (rd_req_i),
        .rd_done_i     (rd_done_i),
        .plan_state_i  (plan_state),
        .plan_op_i     (plan_op),
        .plan_mode_i   (plan_mode),
        .plan_val_i    (plan_val),
        .cur_state_o   (cur_state),
        .send_opcode_o (send_opcode_o),
        .send_mode_o   (send_mode_o),
        .mode_val_o    (mode_val_o),
        .xip_active_o  (xip_active_o)
    );

endmodule

// File: tb/test_xip_mode_tracker.sv
module test_xip_mode_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enter_now = 1'b0;
    logic       enter_next = 1'b0;
    logic       rd_req = 1'b0;
    logic       rd_done = 1'b0;
    logic       send_opcode;
    logic       send_mode;
    logic [7:0] mode_val;
    logic       xip_active;

    int total = 0;
    int bad   = 0;
    bit model_active = 1'b0;

    always #10 clk = ~clk;

    xip_mode_tracker i_xip_mode_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .enter_now_i   (enter_now),
        .enter_next_i  (enter_next),
        .rd_req_i      (rd_req),
        .rd_done_i     (rd_done),
        .send_opcode_o (send_opcode),
        .send_mode_o   (send_mode),
        .mode_val_o    (mode_val),
        .xip_active_o  (xip_active)
    );

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input bit now, input bit nxt, input bit mid_now, input bit mid_nxt,
                           input string tag);
        bit e_op, e_md, e_dur, e_after;
        logic [7:0] e_val;
        if (model_active) begin
            e_op = 1'b0; e_md = 1'b1; e_dur = 1'b1;
            e_val   = (now || nxt) ? 8'hA0 : 8'hFF;
            e_after = now || nxt;
        end else if (now) begin
            e_op = 1'b0; e_md = 1'b1; e_val = 8'hA0; e_dur = 1'b1; e_after = 1'b1;
        end else if (nxt) begin
            e_op = 1'b1; e_md = 1'b1; e_val = 8'hA0; e_dur = 1'b0; e_after = 1'b1;
        end else begin
            e_op = 1'b1; e_md = 1'b0; e_val = mode_val; e_dur = 1'b0; e_after = 1'b0;
        end
        enter_now = now; enter_next = nxt; rd_req = 1'b1;
        cyc();
        rd_req = 1'b0;
        chk({tag, " R9 descriptor"}, {send_opcode, send_mode, mode_val}, {e_op, e_md, e_val});
        chk({tag, " active during"}, {9'd0, xip_active}, {9'd0, e_dur});
        // R7 / R8: change controls and re-request while outstanding
        enter_now = mid_now; enter_next = mid_nxt; rd_req = 1'b1;
        cyc();
        rd_req = 1'b0;
        cyc();
        chk("R7 R8 held while busy", {send_opcode, send_mode, mode_val, xip_active},
            {e_op, e_md, e_val, e_dur});
        rd_done = 1'b1;
        cyc();
        rd_done = 1'b0;
        chk({tag, " active after done"}, {9'd0, xip_active}, {9'd0, e_after});
        model_active = e_after;
        // R8: stray done while idle
        rd_done = 1'b1;
        cyc();
        rd_done = 1'b0;
        chk("R8 idle done ignored", {send_opcode, send_mode, mode_val, xip_active},
            {e_op, e_md, e_val, e_after});
    endtask

    initial begin
        repeat (3) cyc();
        chk("R1 reset", {send_opcode, send_mode, mode_val, xip_active}, {1'b1, 1'b0, 8'hFF, 1'b0});
        rst_n = 1'b1;
        cyc();
        chk("R1 after release", {send_opcode, send_mode, mode_val, xip_active}, {1'b1, 1'b0, 8'hFF, 1'b0});
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 4; c++) begin
                for (int m = 0; m < 4; m++) begin
                    if (s == 1 && !model_active) do_read(1'b1, 1'b0, 1'b0, 1'b0, "setup R4");
                    if (s == 0 && model_active)  do_read(1'b0, 1'b0, 1'b1, 1'b1, "setup R6");
                    do_read(c[1], c[0], m[1], m[0],
                            s == 1 ? ((c != 0) ? "R5" : "R6")
                                   : (c[1] ? "R4" : (c[0] ? "R3" : "R2")));
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule